// File: doc/BRIEF.md
# Extended Register Unlock and Bank Paging Control

This block guards an extended register set behind a fixed 17-byte key. Software writes key bytes one at a time to a dedicated I/O port (the port whose high address byte is BC hex). A match pointer tracks how many consecutive key bytes have been seen. When the final byte matches, the block becomes unlocked and stays that way until reset.

Once unlocked, the block accepts paging commands on a second I/O port (the port whose high address byte is 7F hex). One command maps the extended register bank into the 16 KB memory window at 4000-7FFF hex, and another maps it back out. The bank-mapped flag feeds the memory decoder. Port decoding is done upstream. The block receives one select line per port, plus the write strobe and the data byte.

Top module: `ext_reg_unlock`

## Requirements
- R1: After reset, unlocked_o and bank_mapped_o are both 0.
- R2: A write is accepted as a key byte only when io_wr_i and key_sel_i are both high. The key is FF,00,FF,77,B3,51,A8,D4,62,39,9C,46,2B,15,8A,CD,EE (hex), in that order. unlocked_o goes high on the clock edge that accepts the matching 17th byte, and not before.
- R3: An accepted key byte that does not match the expected byte sets the match pointer to 1 if the byte equals FF (the first key byte). Otherwise it sets the pointer to 0.
- R4: Cycles without io_wr_i, writes with only page_sel_i high, and writes with neither select high leave the match pointer unchanged.
- R5: Once set, unlocked_o stays high until reset. Later key-port writes have no effect on it.
- R6: While unlocked, a paging-port write (io_wr_i and page_sel_i high) of B8 hex sets bank_mapped_o on that clock edge.
- R7: While unlocked, a paging-port write of A0 hex clears bank_mapped_o on that clock edge.
- R8: While locked, paging-port writes have no effect, and bank_mapped_o stays 0.
- R9: A paging-port write of any value other than B8 or A0 hex leaves bank_mapped_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| key_sel_i | input | 1 | Decoded select of the key port |
| page_sel_i | input | 1 | Decoded select of the paging port |
| data_i | input | 8 | Write data byte |
| unlocked_o | output | 1 | Extended registers unlocked |
| bank_mapped_o | output | 1 | Register bank mapped into the memory window |

## Verification
The match pointer is internal. A wrong pointer value does not show at the ports until the rest of the key is written. At that point unlocked_o either fails to rise on the 17th byte or rises early, so the tests finish partial prefixes and check the output after every byte. A wrong pointer fallback after a mismatch, or a pointer disturbed by other-port traffic, shows up at most 16 writes later as a missing or spurious unlock. A wrong mapping state shows on bank_mapped_o one edge after the paging write.

// File: rtl/ext_reg_unlock_pkg.sv
package ext_reg_unlock_pkg;
  localparam int unsigned KEY_LEN = 17;
  localparam int unsigned BYTE_W  = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t key_byte(input int unsigned idx);
    case (idx)
      0:  return 8'hFF;
      1:  return 8'h00;
      2:  return 8'hFF;
      3:  return 8'h77;
      4:  return 8'hB3;
      5:  return 8'h51;
      6:  return 8'hA8;
      7:  return 8'hD4;
      8:  return 8'h62;
      9:  return 8'h39;
      10: return 8'h9C;
      11: return 8'h46;
      12: return 8'h2B;
      13: return 8'h15;
      14: return 8'h8A;
      15: return 8'hCD;
      16: return 8'hEE;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/unlock_matcher.sv
module unlock_matcher
  import ext_reg_unlock_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  logic  sel_i,
  input  byte_t data_i,
  output logic  unlocked_o
);
  localparam int unsigned PTR_W = $clog2(KEY_LEN);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(KEY_LEN - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             unl_q, unl_d;
  logic             accept, hit, restart;

  assign accept  = wr_i && sel_i && !unl_q;
  assign hit     = (data_i == key_byte(int'(ptr_q)));
  assign restart = (data_i == key_byte(0));

  always_comb begin
    ptr_d = ptr_q;
    unl_d = unl_q;
    if (accept) begin
      if (hit) begin
        if (ptr_q == LAST_IDX) begin
          unl_d = 1'b1;
          ptr_d = '0;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end else begin
        // mismatch: fall back, keeping credit for a fresh first byte
        ptr_d = restart ? PTR_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      unl_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      unl_q <= unl_d;
    end
  end

  assign unlocked_o = unl_q;

  p_ptr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST_IDX);

  p_mismatch_fallback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && !unl_q && data_i != key_byte(int'(ptr_q))) |=> (ptr_q <= PTR_W'(1)));

  p_no_write_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_i) |=> ($stable(ptr_q) && $stable(unl_q)));

  p_unlock_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unl_q |=> unl_q);

  p_unlock_on_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unl_q) |-> ($past(ptr_q) == LAST_IDX && $past(wr_i && sel_i)));
endmodule

// File: rtl/bank_page_ctrl.sv
module bank_page_ctrl
  import ext_reg_unlock_pkg::*;
#(
  parameter byte_t MAP_IN_CODE  = 8'hB8,
  parameter byte_t MAP_OUT_CODE = 8'hA0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  logic  sel_i,
  input  byte_t data_i,
  input  logic  unlocked_i,
  output logic  mapped_o
);
  logic mapped_q, mapped_d, cmd;

  assign cmd = wr_i && sel_i && unlocked_i;

  always_comb begin
    mapped_d = mapped_q;
    if (cmd) begin
      if (data_i == MAP_IN_CODE)       mapped_d = 1'b1;
      else if (data_i == MAP_OUT_CODE) mapped_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mapped_q <= 1'b0;
    else         mapped_q <= mapped_d;
  end

  assign mapped_o = mapped_q;

  p_map_in_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && unlocked_i && data_i == MAP_IN_CODE) |=> mapped_q);

  p_map_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && unlocked_i && data_i == MAP_OUT_CODE) |=> !mapped_q);

  p_locked_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |-> !mapped_q);

  p_other_code_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && data_i != MAP_IN_CODE && data_i != MAP_OUT_CODE) |=> $stable(mapped_q));
endmodule

// File: rtl/ext_reg_unlock.sv
module ext_reg_unlock
  import ext_reg_unlock_pkg::*;
#(
  parameter byte_t MAP_IN_CODE  = 8'hB8,
  parameter byte_t MAP_OUT_CODE = 8'hA0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       io_wr_i,
  input  logic       key_sel_i,
  input  logic       page_sel_i,
  input  logic [7:0] data_i,
  output logic       unlocked_o,
  output logic       bank_mapped_o
);
  logic unlocked;

  unlock_matcher u_matcher (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (io_wr_i),
    .sel_i      (key_sel_i),
    .data_i     (data_i),
    .unlocked_o (unlocked)
  );

  bank_page_ctrl #(
    .MAP_IN_CODE  (MAP_IN_CODE),
    .MAP_OUT_CODE (MAP_OUT_CODE)
  ) u_page (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (io_wr_i),
    .sel_i      (page_sel_i),
    .data_i     (data_i),
    .unlocked_i (unlocked),
    .mapped_o   (bank_mapped_o)
  );

  assign unlocked_o = unlocked;

  p_reset_clear_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!unlocked_o && !bank_mapped_o));
endmodule

// File: tb/ext_reg_unlock_bench.sv
module ext_reg_unlock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam int KEY_N = 17;
  localparam logic [7:0] KEY_TB [KEY_N] = '{
    8'hFF, 8'h00, 8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4, 8'h62,
    8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hEE};

  // write targets
  localparam int P_KEY = 0, P_PAGE = 1, P_OTHER = 2, P_NOSTB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0, key_sel = 1'b0, page_sel = 1'b0;
  logic [7:0] data = '0;
  logic unlocked, mapped;

  int n_checks = 0;
  int n_fail = 0;
  int m_ptr = 0;
  bit m_unl = 1'b0;
  bit m_map = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_reg_unlock u_ext_reg_unlock (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .io_wr_i       (io_wr),
    .key_sel_i     (key_sel),
    .page_sel_i    (page_sel),
    .data_i        (data),
    .unlocked_o    (unlocked),
    .bank_mapped_o (mapped)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    io_wr = 1'b0; key_sel = 1'b0; page_sel = 1'b0; data = '0;
    m_ptr = 0; m_unl = 1'b0; m_map = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // model per requirements R2..R9
  task automatic model(input int port, input logic [7:0] d);
    if (port == P_KEY && !m_unl) begin
      if (d == KEY_TB[m_ptr]) begin
        if (m_ptr == KEY_N - 1) begin m_unl = 1'b1; m_ptr = 0; end
        else m_ptr++;
      end else begin
        m_ptr = (d == KEY_TB[0]) ? 1 : 0;
      end
    end else if (port == P_PAGE && m_unl) begin
      if (d == 8'hB8) m_map = 1'b1;
      else if (d == 8'hA0) m_map = 1'b0;
    end
  endtask

  // drive at negedge, outputs settle after the posedge, sample at the following negedge
  task automatic io_write(input int port, input logic [7:0] d);
    io_wr    = (port != P_NOSTB);
    key_sel  = (port == P_KEY) || (port == P_NOSTB);
    page_sel = (port == P_PAGE);
    data     = d;
    @(negedge clk);
    io_wr = 1'b0; key_sel = 1'b0; page_sel = 1'b0; data = '0;
    model(port, d);
  endtask

  task automatic key_range(input int from, input int to, input string tag);
    for (int i = from; i <= to; i++) begin
      io_write(P_KEY, KEY_TB[i]);
      check(tag, unlocked, m_unl);
    end
  endtask

  task automatic t_reset_r1();
    do_reset();
    check("R1 unlocked", unlocked, 1'b0);
    check("R1 mapped", mapped, 1'b0);
  endtask

  task automatic t_full_key_r2_r5();
    do_reset();
    key_range(0, KEY_N - 2, "R2 early");
    check("R2 not before 17th", unlocked, 1'b0);
    io_write(P_KEY, KEY_TB[KEY_N-1]);
    check("R2 unlock on 17th", unlocked, 1'b1);
    io_write(P_KEY, 8'h12);
    io_write(P_KEY, 8'hFF);
    repeat (3) @(negedge clk);
    check("R5 sticky", unlocked, 1'b1);
    do_reset();
    check("R5 cleared by reset", unlocked, 1'b0);
  endtask

  task automatic t_mismatch_r3();
    // mismatch with first key byte keeps pointer at 1
    do_reset();
    key_range(0, 3, "R3 prefix");
    io_write(P_KEY, 8'hFF);
    key_range(1, KEY_N - 1, "R3 resume at 1");
    check("R3 fallback to 1 unlocks", unlocked, 1'b1);
    // plain mismatch returns pointer to 0
    do_reset();
    key_range(0, 5, "R3 prefix");
    io_write(P_KEY, 8'h12);
    key_range(1, KEY_N - 1, "R3 after zero");
    check("R3 fallback to 0 stays locked", unlocked, 1'b0);
    key_range(0, KEY_N - 1, "R3 retry");
    check("R3 full key after zero", unlocked, 1'b1);
  endtask

  task automatic t_other_ports_r4();
    do_reset();
    key_range(0, 7, "R4 prefix");
    io_write(P_PAGE, 8'h12);
    io_write(P_OTHER, 8'h00);
    io_write(P_NOSTB, 8'h33);
    repeat (4) @(negedge clk);
    key_range(8, KEY_N - 2, "R4 resume");
    check("R4 not yet", unlocked, 1'b0);
    io_write(P_KEY, KEY_TB[KEY_N-1]);
    check("R4 pointer preserved", unlocked, 1'b1);
  endtask

  task automatic t_locked_page_r8();
    do_reset();
    io_write(P_PAGE, 8'hB8);
    check("R8 locked map-in ignored", mapped, 1'b0);
    key_range(0, 9, "R8 partial");
    io_write(P_PAGE, 8'hB8);
    check("R8 partial key map-in ignored", mapped, 1'b0);
  endtask

  task automatic t_paging_r6_r7_r9();
    do_reset();
    key_range(0, KEY_N - 1, "R6 unlock");
    check("R6 precondition", unlocked, 1'b1);
    io_write(P_PAGE, 8'hB8);
    check("R6 map in", mapped, 1'b1);
    io_write(P_PAGE, 8'h55);
    check("R9 other code holds 1", mapped, m_map);
    io_write(P_KEY, 8'hA0);
    check("R9 key port A0 holds", mapped, 1'b1);
    io_write(P_OTHER, 8'hA0);
    check("R9 other port holds", mapped, 1'b1);
    io_write(P_PAGE, 8'hA0);
    check("R7 map out", mapped, 1'b0);
    io_write(P_PAGE, 8'hB9);
    check("R9 other code holds 0", mapped, 1'b0);
    io_write(P_PAGE, 8'hB8);
    check("R6 map in again", mapped, 1'b1);
  endtask

  initial begin
    t_reset_r1();
    t_full_key_r2_r5();
    t_mismatch_r3();
    t_other_ports_r4();
    t_locked_page_r8();
    t_paging_r6_r7_r9();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule